// File: doc/BRIEF.md
# Configurable Pad Register Cell

This cell sits between one bidirectional pin and the core logic. It holds three storage elements: one captures the pin value for the core, one holds the value to be driven out, and one holds the driver enable. All three share one clock and one set/reset line, and each has its own clock enable. Static configuration inputs choose, for each element separately, flop or latch behaviour, one of four set/reset behaviours, and whether its path goes through the element or around it. Every data and control signal has its own polarity inversion bit.

The pin is modelled behaviourally. The cell reports whether its own driver is on, the resolved logic level, and whether the pin is floating. An external driver can be applied through two inputs. An optional keeper holds the last driven level when nothing drives the pin. Until configuration is done, the output driver stays off and every element is held at its configured initial value.

Top module: `ioc_cell`

## Requirements
- R1: While `rst_n` is low at an active clock edge (with `cfg_done` high), each element loads its initial value. The initial value is 1 for set/reset code 0 (synchronous set) and code 2 (asynchronous preset), and 0 for code 1 (synchronous reset) and code 3 (asynchronous clear).
- R2: In flop mode (`cfg_latch` bit 0), an element takes its data at the active clock edge when its effective clock enable is 1, and keeps its value when it is 0.
- R3: In latch mode (`cfg_latch` bit 1), an element is transparent while the effective clock is high and holds its value while it is low.
- R4: With set/reset codes 2 or 3, an active effective set/reset forces the element to 1 or 0 at once, with no clock edge and whatever the clock enable is.
- R5: With set/reset codes 0 or 1, the set/reset acts only at an active clock edge, and it wins over the clock enable.
- R6: `cfg_reg` bit 0 (input), bit 1 (output data) and bit 2 (enable) route each path through its element when 1, or straight through when 0.
- R7: `cfg_inv_clk`=1 makes the falling clock edge active. `cfg_inv_ce[i]` inverts enable i, `cfg_inv_sr` inverts set/reset, and `cfg_inv_data` bits 0/1/2 invert the input, output and enable data.
- R8: While `cfg_done` is 0, `pad_drv` is 0 and every element is held at its initial value without a clock edge.
- R9: With `cfg_keeper`=1 and no driver active, `pad_level` holds the last driven level and `pad_float` is 0. With the keeper off and no driver, `pad_float` is 1 and `pad_level` is 0.
- R10: When the cell drives, `pad_level` equals the cell's output value even if the external driver is active. Otherwise it equals `ext_drv_val` while `ext_drv_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, also the latch gate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_done | input | 1 | Configuration complete |
| cfg_latch | input | 3 | Per element: 1 = latch, 0 = flop (0 in, 1 out, 2 enable) |
| cfg_sr_mode | input | 3x2 | Per element set/reset code 0..3 |
| cfg_reg | input | 3 | Per path: 1 = through element, 0 = bypass |
| cfg_inv_clk | input | 1 | Clock polarity invert |
| cfg_inv_ce | input | 3 | Per element clock-enable invert |
| cfg_inv_sr | input | 1 | Set/reset invert |
| cfg_inv_data | input | 3 | Input, output and enable data invert |
| cfg_keeper | input | 1 | Keeper select |
| sr | input | 1 | Shared set/reset |
| ce | input | 3 | Per element clock enable |
| core_out | input | 1 | Output data from core |
| core_oe | input | 1 | Driver enable from core |
| core_in | output | 1 | Input data to core |
| ext_drv_en | input | 1 | External driver active on the pin |
| ext_drv_val | input | 1 | External driver value |
| pad_drv | output | 1 | Cell driver is on |
| pad_level | output | 1 | Resolved pin level |
| pad_float | output | 1 | Pin undriven and unkept |

## Verification
The assertions assume that the configuration is static around any window in which they observe an element. A set/reset code or inversion may change only while the effective set/reset is inactive, or only to start an asynchronous action. They also assume that a keeper hold interval is not interrupted between two clock edges. The stimulus follows these rules. It changes configuration only between edges, with `sr` low. It flips the clock polarity only while the clock is high and the enables are low. It opens and closes the keeper window entirely within one half cycle.

// File: rtl/ioc_pkg.sv
// ioc_pkg: shared types and helpers for the pad register cell.
// Assumes three elements indexed input, output data, enable.
package ioc_pkg;
    localparam int N_ELEM = 3;
    localparam int SRM_W  = 2;
    localparam int EL_IN  = 0;
    localparam int EL_OUT = 1;
    localparam int EL_OE  = 2;

    typedef enum logic [SRM_W-1:0] {
        SRM_SYNC_SET  = 2'd0,
        SRM_SYNC_RST  = 2'd1,
        SRM_ASYNC_SET = 2'd2,
        SRM_ASYNC_CLR = 2'd3
    } srm_e;

    // Value an element takes on any set/reset, reset or unconfigured hold
    function automatic logic srm_init(srm_e m);
        return (m == SRM_SYNC_SET) || (m == SRM_ASYNC_SET);
    endfunction

    // True when the set/reset acts without a clock edge
    function automatic logic srm_is_async(srm_e m);
        return (m == SRM_ASYNC_SET) || (m == SRM_ASYNC_CLR);
    endfunction
endpackage

// File: rtl/ioc_store.sv
// ioc_store: one storage element, usable as an edge flop or a level latch.
// Every set/reset, reset or unconfigured hold loads one per-mode initial
// value. Assumes clk_g, ce_act and sr_act already carry polarity choices.
module ioc_store
    import ioc_pkg::*;
(
    input  logic clk_g,
    input  logic rst_n,
    input  logic hold_cfg,
    input  logic sr_act,
    input  logic ce_act,
    input  logic d,
    input  logic latch_mode,
    input  srm_e sr_mode,
    output logic q
);
    logic init_v;
    logic is_async;
    logic async_on;
    logic ff_q;
    logic lt_q;

    assign init_v   = srm_init(sr_mode);
    assign is_async = srm_is_async(sr_mode);
    assign async_on = hold_cfg | (sr_act & is_async);

    // Edge-triggered variant with asynchronous force to the initial value
    always_ff @(posedge clk_g or posedge async_on) begin
        if (async_on) begin
            ff_q <= init_v;
        end else if (!rst_n || sr_act) begin
            ff_q <= init_v;
        end else if (ce_act) begin
            ff_q <= d;
        end
    end

    // Level-sensitive variant, gate open while clk_g is high
    always_latch begin
        if (hold_cfg || (sr_act && is_async)) begin
            lt_q = init_v;
        end else if (clk_g) begin
            if (!rst_n || sr_act) begin
                lt_q = init_v;
            end else if (ce_act) begin
                lt_q = d;
            end
        end
    end

    // Pick the variant selected by configuration
    assign q = latch_mode ? lt_q : ff_q;

    AST_ASYNC_HOLD: assert property (@(posedge clk_g) disable iff (!rst_n)
        (hold_cfg || (sr_act && is_async)) |-> (q == init_v)); // R4

    AST_SYNC_OVER_CE: assert property (@(posedge clk_g) disable iff (!rst_n)
        (!latch_mode && sr_act && !is_async && !hold_cfg)
        |=> (q == $past(init_v)) || latch_mode || hold_cfg || (sr_act && is_async)); // R5

    AST_CE_HOLD: assert property (@(posedge clk_g) disable iff (!rst_n)
        (!latch_mode && !ce_act && !sr_act && !hold_cfg)
        |=> $stable(q) || (q == init_v) || latch_mode); // R2
endmodule

// File: rtl/ioc_pad.sv
// ioc_pad: behavioural pin resolution with an optional keeper.
// The cell driver wins over the external driver; contention is not modelled.
module ioc_pad (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en,
    input  logic drv_val,
    input  logic ext_en,
    input  logic ext_val,
    input  logic keeper_en,
    output logic level,
    output logic floating
);
    logic held;
    logic undriven;

    assign undriven = !drv_en && !ext_en;

    // Keeper remembers the last level actually driven onto the pin
    always_latch begin
        if (!undriven) begin
            held = drv_en ? drv_val : ext_val;
        end
    end

    // Resolve the pin level: own driver, external driver, keeper, else low
    always_comb begin
        if (drv_en)         level = drv_val;
        else if (ext_en)    level = ext_val;
        else if (keeper_en) level = held;
        else                level = 1'b0;
    end

    assign floating = undriven && !keeper_en;

    AST_KEEPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (keeper_en && undriven) |=> !(keeper_en && undriven) || $stable(level)); // R9
endmodule

// File: rtl/ioc_cell.sv
// ioc_cell: pad register cell with input, output data and enable elements.
// Applies polarity inversion, routes each path through or around its
// element, and gates the driver until configuration is done.
// Assumes configuration inputs are quasi-static.
module ioc_cell
    import ioc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_done,
    input  logic [N_ELEM-1:0]            cfg_latch,
    input  logic [N_ELEM-1:0][SRM_W-1:0] cfg_sr_mode,
    input  logic [N_ELEM-1:0]            cfg_reg,
    input  logic                         cfg_inv_clk,
    input  logic [N_ELEM-1:0]            cfg_inv_ce,
    input  logic                         cfg_inv_sr,
    input  logic [N_ELEM-1:0]            cfg_inv_data,
    input  logic                         cfg_keeper,
    input  logic                         sr,
    input  logic [N_ELEM-1:0]            ce,
    input  logic                         core_out,
    input  logic                         core_oe,
    output logic                         core_in,
    input  logic                         ext_drv_en,
    input  logic                         ext_drv_val,
    output logic                         pad_drv,
    output logic                         pad_level,
    output logic                         pad_float
);
    logic              clk_g;
    logic              sr_act;
    logic              hold_cfg;
    logic [N_ELEM-1:0] ce_act;
    logic              d_in, d_out, d_oe;
    logic              q_in, q_out, q_oe;
    logic              sel_out, sel_oe;

    // Apply control polarities shared by the three elements
    assign clk_g    = clk ^ cfg_inv_clk;
    assign sr_act   = sr ^ cfg_inv_sr;
    assign hold_cfg = !cfg_done;
    assign ce_act   = ce ^ cfg_inv_ce;

    // Data polarities at the element inputs
    assign d_in  = pad_level ^ cfg_inv_data[EL_IN];
    assign d_out = core_out ^ cfg_inv_data[EL_OUT];
    assign d_oe  = core_oe ^ cfg_inv_data[EL_OE];

    for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
        logic d_w;
        logic q_w;
        if (g == EL_IN) begin : g_in
            assign d_w  = d_in;
            assign q_in = q_w;
        end else if (g == EL_OUT) begin : g_out
            assign d_w   = d_out;
            assign q_out = q_w;
        end else begin : g_oe
            assign d_w  = d_oe;
            assign q_oe = q_w;
        end

        ioc_store u_store (
            .clk_g      (clk_g),
            .rst_n      (rst_n),
            .hold_cfg   (hold_cfg),
            .sr_act     (sr_act),
            .ce_act     (ce_act[g]),
            .d          (d_w),
            .latch_mode (cfg_latch[g]),
            .sr_mode    (srm_e'(cfg_sr_mode[g])),
            .q          (q_w)
        );
    end

    // Registered or bypassed selection per path
    assign core_in = cfg_reg[EL_IN]  ? q_in  : d_in;
    assign sel_out = cfg_reg[EL_OUT] ? q_out : d_out;
    assign sel_oe  = cfg_reg[EL_OE]  ? q_oe  : d_oe;
    assign pad_drv = cfg_done & sel_oe;

    ioc_pad u_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .drv_en    (pad_drv),
        .drv_val   (sel_out),
        .ext_en    (ext_drv_en),
        .ext_val   (ext_drv_val),
        .keeper_en (cfg_keeper),
        .level     (pad_level),
        .floating  (pad_float)
    );

    AST_UNCONF_NODRV: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !pad_drv); // R8
endmodule

// File: tb/ioc_cell_tb.sv
`timescale 1ns/1ps
module ioc_cell_tb_top;
    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_done;
    logic [2:0]      cfg_latch;
    logic [2:0][1:0] cfg_sr_mode;
    logic [2:0]      cfg_reg;
    logic            cfg_inv_clk;
    logic [2:0]      cfg_inv_ce;
    logic            cfg_inv_sr;
    logic [2:0]      cfg_inv_data;
    logic            cfg_keeper;
    logic            sr;
    logic [2:0]      ce;
    logic            core_out, core_oe, core_in;
    logic            ext_drv_en, ext_drv_val;
    logic            pad_drv, pad_level, pad_float;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Table of {ce_out, sr, core_out, expected pad_level} for flop mode, sync reset
    localparam logic [3:0] VEC [0:7] = '{
        4'b1011, 4'b0001, 4'b1000, 4'b1011,
        4'b0110, 4'b1110, 4'b0010, 4'b1011
    };

    always #4 clk = ~clk;

    ioc_cell dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .cfg_latch(cfg_latch),
        .cfg_sr_mode(cfg_sr_mode), .cfg_reg(cfg_reg), .cfg_inv_clk(cfg_inv_clk),
        .cfg_inv_ce(cfg_inv_ce), .cfg_inv_sr(cfg_inv_sr), .cfg_inv_data(cfg_inv_data),
        .cfg_keeper(cfg_keeper), .sr(sr), .ce(ce), .core_out(core_out),
        .core_oe(core_oe), .core_in(core_in), .ext_drv_en(ext_drv_en),
        .ext_drv_val(ext_drv_val), .pad_drv(pad_drv), .pad_level(pad_level),
        .pad_float(pad_float)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_done = 0; cfg_latch = 3'b000;
        cfg_sr_mode[0] = 2'd0; cfg_sr_mode[1] = 2'd1; cfg_sr_mode[2] = 2'd1;
        cfg_reg = 3'b011; cfg_inv_clk = 0; cfg_inv_ce = 3'b000; cfg_inv_sr = 0;
        cfg_inv_data = 3'b000; cfg_keeper = 0; sr = 0; ce = 3'b000;
        core_out = 0; core_oe = 1; ext_drv_en = 0; ext_drv_val = 0;

        // Reset and unconfigured state
        tick(); tick();
        chk("R8 driver off while unconfigured", pad_drv, 1'b0);
        chk("R8 input element held at init", core_in, 1'b1);
        cfg_done = 1;
        tick();
        chk("R1 driver on after config", pad_drv, 1'b1);
        chk("R1 output element reset value", pad_level, 1'b0);
        chk("R1 input element set value", core_in, 1'b1);
        rst_n = 1;

        // Table walk: flop mode, enable and sync reset priority (R2, R5)
        for (int i = 0; i < 8; i++) begin
            ce[1] = VEC[i][3]; sr = VEC[i][2]; core_out = VEC[i][1];
            tick();
            chk($sformatf("R2/R5 vector %0d", i), pad_level, VEC[i][0]);
        end
        sr = 0; ce = 3'b000;

        // Configuration drop forces init with no edge (q_out was 1)
        cfg_done = 0; #1;
        chk("R8 driver off on drop", pad_drv, 1'b0);
        cfg_done = 1; #1;
        chk("R8 output element forced to init", pad_level, 1'b0);

        // Sync set waits for an edge
        cfg_sr_mode[1] = 2'd0; sr = 1; #1;
        chk("R5 sync set not immediate", pad_level, 1'b0);
        tick();
        chk("R5 sync set at edge", pad_level, 1'b1);
        sr = 0;

        // Async clear and preset
        cfg_sr_mode[1] = 2'd3; #1;
        sr = 1; #1;
        chk("R4 async clear immediate", pad_level, 1'b0);
        ce[1] = 1; core_out = 1;
        tick();
        chk("R4 async clear beats enable", pad_level, 1'b0);
        sr = 0; cfg_sr_mode[1] = 2'd2; core_out = 0;
        tick();
        ce[1] = 0; sr = 1; #1;
        chk("R4 async preset immediate", pad_level, 1'b1);
        sr = 0; #1;

        // Inverted set/reset triggers clear with sr low
        cfg_sr_mode[1] = 2'd3; #1;
        cfg_inv_sr = 1; #1;
        chk("R7 inverted set/reset", pad_level, 1'b0);
        cfg_inv_sr = 0; cfg_sr_mode[1] = 2'd1;

        // Inverted clock enable
        cfg_inv_ce[1] = 1; ce[1] = 0; core_out = 1;
        tick();
        chk("R7 inverted clock enable captures", pad_level, 1'b1);
        cfg_inv_ce[1] = 0;

        // Inverted clock: falling edge is active (at posedge+1 now)
        cfg_inv_clk = 1; core_out = 0; ce[1] = 1;
        #2;
        chk("R7 no capture before falling edge", pad_level, 1'b1);
        #2;
        chk("R7 capture on falling edge", pad_level, 1'b0);
        ce[1] = 0;
        tick();
        cfg_inv_clk = 0;

        // Output data bypass and inversion
        cfg_reg[1] = 0; core_out = 1; #1;
        chk("R6 output bypass follows core", pad_level, 1'b1);
        cfg_inv_data[1] = 1; #1;
        chk("R7 output data inverted", pad_level, 1'b0);
        cfg_inv_data[1] = 0;

        // Enable inversion
        cfg_inv_data[2] = 1; core_oe = 1; #1;
        chk("R7 enable inverted off", pad_drv, 1'b0);
        core_oe = 0; #1;
        chk("R7 enable inverted on", pad_drv, 1'b1);
        cfg_inv_data[2] = 0; core_oe = 1;

        // Registered enable: synchronous enable and disable
        cfg_reg[2] = 1; ce[2] = 1; #1;
        chk("R6 registered enable starts off", pad_drv, 1'b0);
        tick();
        chk("R6 registered enable turns on at edge", pad_drv, 1'b1);
        core_oe = 0; #1;
        chk("R6 registered enable holds until edge", pad_drv, 1'b1);
        tick();
        chk("R6 registered enable turns off at edge", pad_drv, 1'b0);
        cfg_reg[2] = 0; ce[2] = 0;

        // Input path bypass and registered capture
        ext_drv_en = 1; ext_drv_val = 1; cfg_reg[0] = 0; #1;
        chk("R6 input bypass high", core_in, 1'b1);
        ext_drv_val = 0; #1;
        chk("R6 input bypass low", core_in, 1'b0);
        cfg_reg[0] = 1; #1;
        chk("R6 input registered keeps old", core_in, 1'b1);
        ce[0] = 1;
        tick();
        chk("R6 input registered captures", core_in, 1'b0);
        cfg_inv_data[0] = 1;
        tick();
        chk("R7 input data inverted", core_in, 1'b1);
        ce[0] = 0; cfg_inv_data[0] = 0;

        // Own driver priority over external driver
        core_oe = 1; core_out = 0; ext_drv_val = 1; #1;
        chk("R10 own driver wins", pad_level, 1'b0);
        core_oe = 0; #1;
        chk("R10 external driver seen", pad_level, 1'b1);

        // Keeper
        cfg_keeper = 1; ext_drv_en = 0; #1;
        chk("R9 keeper holds level", pad_level, 1'b1);
        chk("R9 keeper not floating", pad_float, 1'b0);
        ext_drv_val = 0; #1;
        chk("R9 keeper ignores idle external value", pad_level, 1'b1);
        cfg_keeper = 0; #1;
        chk("R9 floating without keeper", pad_float, 1'b1);
        chk("R9 floating level low", pad_level, 1'b0);

        // Latch mode on the output path
        core_oe = 1; cfg_reg[1] = 1; cfg_latch[1] = 1; ce[1] = 1;
        @(posedge clk); #1;
        core_out = 1; #1;
        chk("R3 latch transparent while gate high", pad_level, 1'b1);
        @(negedge clk); #1;
        core_out = 0; #1;
        chk("R3 latch holds while gate low", pad_level, 1'b1);
        @(posedge clk); #1;
        chk("R3 latch follows when gate reopens", pad_level, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule